// File: doc/BRIEF.md
# Keyed Self-Clearing Warm Reset Register

This block holds two small software-visible registers that together gate a warm reset request. An 8-bit key register must first be loaded with an unlock value. Only then does a write that clears the request bit of the control register take effect. Once that write is accepted, the active-low warm reset line goes low. A counter sized from the system clock frequency then returns the line high on its own after one microsecond.

Software loads the key, writes the control register with the request bit at zero, and afterwards overwrites the key with a different value so that a stray write cannot start another pulse. Both registers can be read back at all times. The control register shows only the state of the request bit. Nothing downstream of the reset line belongs to this block.

Top module: `warm_reset_keyed`

## Requirements
- R1: After reset, `warm_rst_n` is 1, `ctrl_rdata` is 0x20 and `key_rdata` is 0x00.
- R2: A write (`wr_en`=1) to address 14 loads all 8 bits of `wr_data` into the key register, and `key_rdata` shows the value from the cycle after the write clock edge.
- R3: A write to address 13 with `wr_data` bit 5 at 0, while the key holds 0xA8, drives `warm_rst_n` low from the cycle after the write clock edge.
- R4: Once low, `warm_rst_n` stays low for exactly PULSE_CYC = CLK_HZ/1,000,000 × PULSE_US clock cycles, then returns to 1 without any further write.
- R5: A write of 0 to bit 5 of address 13 while the key differs from 0xA8 is ignored, and `warm_rst_n` stays 1.
- R6: Writes to address 13 while a pulse is running, whatever their bit 5, neither lengthen nor shorten the pulse.
- R7: `ctrl_rdata` is always {2'b00, `warm_rst_n`, 5'b00000`}`. Bits 7:6 and 4:0 read 0 whatever was written.
- R8: Writes with `wr_en` low, or to any address other than 13, start no pulse. Writes to any address other than 14 leave the key unchanged.
- R9: The key keeps its value through and after a pulse, so a second accepted write starts a second pulse until software changes the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address (13 control, 14 key) |
| wr_data | input | 8 | Register write data |
| warm_rst_n | output | 1 | Active-low warm reset request line |
| ctrl_rdata | output | 8 | Control register readback |
| key_rdata | output | 8 | Key register readback |

## Verification
The hardest state to reach is a write that arrives while a pulse is already running. From outside, the only hint that a pulse is active is the low reset line. The bench therefore starts a pulse and counts cycles at the ports. In the middle of the pulse it writes a clearing value and a setting value to the control address, then checks that the total low time is still exactly one pulse. All 256 key values are swept against a clearing write, and all 256 control data values are swept with the key unlocked. This covers the unlock gate and the read-as-zero bits arithmetically.

// File: rtl/warm_reset_keyed.sv
module warm_reset_keyed #(
  parameter int              CLK_HZ    = 100_000_000,
  parameter int              PULSE_US  = 1,
  parameter int              ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'd13,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 4'd14,
  parameter logic [7:0]      UNLOCK    = 8'hA8,
  parameter int              REQ_BIT   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              warm_rst_n,
  output logic [7:0]        ctrl_rdata,
  output logic [7:0]        key_rdata
);
  localparam int PULSE_CYC = CLK_HZ / 1_000_000 * PULSE_US;
  localparam int CNT_W     = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;

  logic [7:0]       key_q;
  logic             req_n_q;
  logic [CNT_W-1:0] cnt_q;

  wire ctrl_hit = wr_en && (wr_addr == CTRL_ADDR);
  wire arm      = ctrl_hit && !wr_data[REQ_BIT] && (key_q == UNLOCK) && req_n_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                key_q <= 8'h00;
    else if (wr_en && (wr_addr == KEY_ADDR))   key_q <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_n_q <= 1'b1;
      cnt_q   <= '0;
    end else if (arm) begin
      req_n_q <= 1'b0;
      cnt_q   <= CNT_W'(PULSE_CYC - 1);
    end else if (!req_n_q) begin
      if (cnt_q == '0) req_n_q <= 1'b1;
      else             cnt_q   <= cnt_q - 1'b1;
    end

  assign warm_rst_n = req_n_q;
  assign ctrl_rdata = req_n_q ? (8'h01 << REQ_BIT) : 8'h00;
  assign key_rdata  = key_q;
endmodule

// File: rtl/warm_reset_keyed_chk.sv
module warm_reset_keyed_chk #(
  parameter int              CLK_HZ    = 100_000_000,
  parameter int              PULSE_US  = 1,
  parameter int              ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'd13,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 4'd14,
  parameter logic [7:0]      UNLOCK    = 8'hA8,
  parameter int              REQ_BIT   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              warm_rst_n,
  input logic [7:0]        ctrl_rdata,
  input logic [7:0]        key_rdata
);
  localparam int PULSE_CYC = CLK_HZ / 1_000_000 * PULSE_US;
  localparam int LW        = $clog2(PULSE_CYC + 2) + 1;

  logic [LW-1:0] low_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 low_cnt <= '0;
    else if (warm_rst_n)        low_cnt <= '0;
    else if (low_cnt != '1)     low_cnt <= low_cnt + 1'b1;

  p_start_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(warm_rst_n) |-> ($past(key_rdata) == UNLOCK) && $past(wr_en)
                          && ($past(wr_addr) == CTRL_ADDR) && !$past(wr_data[REQ_BIT]));

  p_release_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warm_rst_n) |-> ($past(low_cnt) == LW'(PULSE_CYC - 1)));

  p_no_extend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !warm_rst_n |-> (low_cnt < LW'(PULSE_CYC)));

  p_key_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == KEY_ADDR)) |=> (key_rdata == $past(wr_data)));

  p_key_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (wr_addr == KEY_ADDR)) |=> $stable(key_rdata));
endmodule

bind warm_reset_keyed warm_reset_keyed_chk #(
  .CLK_HZ(CLK_HZ), .PULSE_US(PULSE_US), .ADDR_W(ADDR_W),
  .CTRL_ADDR(CTRL_ADDR), .KEY_ADDR(KEY_ADDR), .UNLOCK(UNLOCK), .REQ_BIT(REQ_BIT)
) u_chk (.*);

// File: tb/warm_reset_keyed_tb.sv
module warm_reset_keyed_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  TB_HZ      = 8_000_000;
  localparam int  N          = TB_HZ / 1_000_000;
  localparam logic [3:0] A_CTRL = 4'd13, A_KEY = 4'd14;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic warm_rst_n;
  logic [7:0] ctrl_rdata, key_rdata;
  int compared = 0, mismatched = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  warm_reset_keyed #(.CLK_HZ(TB_HZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .warm_rst_n(warm_rst_n), .ctrl_rdata(ctrl_rdata), .key_rdata(key_rdata));

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (!warm_rst_n && n < 4*N) begin n++; @(negedge clk); end
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100_000) begin
        mismatched++; compared++;
        $display("FAIL watchdog: actual %0d expected <100000", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 warm_rst_n", warm_rst_n, 1);
    chk("R1 ctrl", ctrl_rdata, 8'h20);
    chk("R1 key", key_rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3/R5/R4: sweep every key value against a clearing write
    for (int k = 0; k < 256; k++) begin
      wr(A_KEY, 8'(k));
      chk("R2 key readback", key_rdata, k);
      wr(A_CTRL, 8'h00);
      if (k == 8'hA8) begin
        chk("R3 pulse start", warm_rst_n, 0);
        chk("R7 ctrl low", ctrl_rdata, 8'h00);
        measure(n);
        chk("R4 pulse length", n, N);
        chk("R7 ctrl released", ctrl_rdata, 8'h20);
        chk("R9 key kept", key_rdata, 8'hA8);
      end else begin
        chk("R5 locked ignored", warm_rst_n, 1);
      end
    end

    // R7: every control data value with the key unlocked
    wr(A_KEY, 8'hA8);
    for (int d = 0; d < 256; d++) begin
      wr(A_CTRL, 8'(d));
      chk("R7 ctrl readback", ctrl_rdata, (d & 8'h20) ? 8'h20 : 8'h00);
      measure(n);
      chk("R4 pulse length sweep", n, (d & 8'h20) ? 0 : N);
    end

    // R6: writes during a pulse
    wr(A_CTRL, 8'h00);
    n = 0;
    for (int i = 0; i < 4*N; i++) begin
      if (!warm_rst_n) n++;
      if (i == 2 || i == 4) begin
        wr_en = 1'b1; wr_addr = A_CTRL; wr_data = (i == 2) ? 8'h00 : 8'h20;
      end else wr_en = 1'b0;
      @(negedge clk);
    end
    chk("R6 no extend or cut", n, N);

    // R8: strobe low and foreign addresses
    @(negedge clk); wr_en = 1'b0; wr_addr = A_CTRL; wr_data = 8'h00;
    @(negedge clk);
    chk("R8 strobe low", warm_rst_n, 1);
    for (int a = 0; a < 16; a++) begin
      if (a == 13 || a == 14) continue;
      wr(4'(a), 8'h00);
      chk("R8 other addr no pulse", warm_rst_n, 1);
      chk("R8 other addr key", key_rdata, 8'hA8);
    end

    // R9: key still unlocked, second pulse; then relock
    wr(A_CTRL, 8'hDF);
    chk("R9 second pulse", warm_rst_n, 0);
    measure(n);
    chk("R9 second length", n, N);
    wr(A_KEY, 8'h00);
    wr(A_CTRL, 8'h00);
    chk("R5 relocked", warm_rst_n, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule